// File: doc/BRIEF.md
# DAC Output Buffer Offset Trim Sequencer

This block runs a user offset trim for one buffered DAC channel. A start pulse begins a calibration. The block then isolates the channel output by driving a high-impedance enable and forces the converter code to mid-scale. It walks a 5-bit trim value upward from zero and watches a single-bit comparator flag. The flag reports whether the buffered mid-scale output sits above or below half the reference. The first trim setting at which the flag departs from the value it had at trim zero becomes the result.

Calibration only makes sense while the output buffer is in circuit. A 3-bit channel mode field is therefore checked when the start pulse arrives, and the start pulse is dropped for modes without the buffer. Outside calibration, software may load the trim value directly. After reset, the trim value comes from a factory default input. A done pulse marks the end of each calibration. An error status marks a sweep that reached the top trim value without seeing the flag change.

Top module: `dac_trim_cal`

## Requirements
- R1: While rst_ni is low and after its release, trim_o equals factory_trim_i, and busy_o, done_o, err_o, hiz_o and force_en_o are 0.
- R2: A start_i sampled while idle with mode_i in {000, 001, 100, 101} (mode_i[1] = 0) sets busy_o, hiz_o and force_en_o on the next cycle. While busy_o is high, force_code_o is 12'h800. When not busy, force_code_o is 0.
- R3: The search loads trim_o = 0 on the accepting edge and raises it by exactly one per step. Each step lasts settle_i + 1 cycles, and cmp_flag_i is sampled in the last cycle of the step. The sample at trim 0 is the reference.
- R4: The search ends at the first step whose sampled flag differs from the reference. trim_o keeps that step's value, and busy_o falls. A toggle first seen at trim k keeps busy_o high for (k+1)*(settle_i+1) cycles.
- R5: A start_i with mode_i in {010, 011, 110, 111} (mode_i[1] = 1) is ignored: busy_o stays 0, and trim_o and done_o are unchanged.
- R6: done_o is a one-cycle pulse, raised on the edge where busy_o falls.
- R7: If the flag has not changed by the step at trim 31, the block ends with trim_o = 31 and err_o = 1. err_o stays set until the next accepted start clears it.
- R8: sw_trim_we_i while idle loads sw_trim_i into trim_o on the next cycle. While busy_o is high, the write is ignored.
- R9: A start_i seen while busy_o is high is ignored, and the running search keeps its duration and result.
- R10: If an accepted start_i and sw_trim_we_i arrive in the same idle cycle, the start wins and trim_o becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| factory_trim_i | input | 5 | Trim value loaded at reset |
| mode_i | input | 3 | Channel mode; bit 1 low means buffer enabled |
| start_i | input | 1 | Calibration start pulse |
| settle_i | input | 8 | Extra settle cycles per step |
| cmp_flag_i | input | 1 | Comparator flag from the buffer |
| sw_trim_we_i | input | 1 | Software trim write strobe |
| sw_trim_i | input | 5 | Software trim write data |
| trim_o | output | 5 | Current trim value |
| hiz_o | output | 1 | Output isolation (high impedance) enable |
| force_en_o | output | 1 | Forced-code select |
| force_code_o | output | 12 | Forced converter code |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Calibration finished pulse |
| err_o | output | 1 | No flag change found |

## Verification
Some properties are checked on every cycle:
- busy implies isolation and the mid-scale code;
- the trim value moves by at most one step while busy and starts from zero;
- done is a single-cycle pulse that comes only as busy falls;
- an error ending leaves the trim at its top value;
- starts in unbuffered modes never raise busy.

Other behaviour only the bench can show. Its sweeps cover:
- every toggle position from 1 through 32 (none), several settle counts and both flag polarities, which give the step duration and the exact result;
- blocked software writes and ignored restarts during a run;
- the start-over-write priority;
- the error bit clearing on the next start.

// File: rtl/dac_trim_pkg.sv
package dac_trim_pkg;
  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_REF    = 2'd1,
    CAL_SEARCH = 2'd2
  } cal_state_e;

  // modes whose bit 1 is low keep the output buffer in circuit
  localparam int unsigned MODE_W = 3;
  localparam int unsigned N_MODES = 1 << MODE_W;
endpackage

// File: rtl/dac_trim_mode_dec.sv
module dac_trim_mode_dec
  import dac_trim_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output logic              buf_en_o
);
  logic [N_MODES-1:0] buf_mask;

  for (genvar m = 0; m < N_MODES; m++) begin : g_mask
    assign buf_mask[m] = ((m >> 1) & 1) == 0;
  end

  assign buf_en_o = buf_mask[mode_i];
endmodule

// File: rtl/dac_trim_settle.sv
module dac_trim_settle #(
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                restart_i,
  input  logic                run_i,
  input  logic [SETTLE_W-1:0] limit_i,
  output logic                expire_o
);
  logic [SETTLE_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (run_i && !expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dac_trim_reg.sv
module dac_trim_reg #(
  parameter int unsigned TRIM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TRIM_W-1:0] factory_i,
  input  logic              clr_i,
  input  logic              inc_i,
  input  logic              busy_i,
  input  logic              we_i,
  input  logic [TRIM_W-1:0] wdata_i,
  output logic [TRIM_W-1:0] trim_o,
  output logic              at_max_o
);
  logic [TRIM_W-1:0] trim_q;

  assign trim_o   = trim_q;
  assign at_max_o = &trim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              trim_q <= factory_i;
    else if (clr_i)           trim_q <= '0;
    else if (inc_i)           trim_q <= trim_q + 1'b1;
    else if (we_i && !busy_i) trim_q <= wdata_i;
  end
endmodule

// File: rtl/dac_trim_fsm.sv
module dac_trim_fsm
  import dac_trim_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic buf_en_i,
  input  logic expire_i,
  input  logic flag_i,
  input  logic at_max_i,
  output logic busy_o,
  output logic trim_clr_o,
  output logic trim_inc_o,
  output logic restart_o,
  output logic done_o,
  output logic err_o
);
  cal_state_e state_q, state_d;
  logic ref_q, ref_d;
  logic fin, err_set;
  logic done_q, err_q;

  always_comb begin
    state_d    = state_q;
    ref_d      = ref_q;
    trim_clr_o = 1'b0;
    trim_inc_o = 1'b0;
    restart_o  = 1'b0;
    fin        = 1'b0;
    err_set    = 1'b0;
    unique case (state_q)
      CAL_IDLE: begin
        if (start_i && buf_en_i) begin
          state_d    = CAL_REF;
          trim_clr_o = 1'b1;
          restart_o  = 1'b1;
        end
      end
      CAL_REF: begin
        if (expire_i) begin
          ref_d      = flag_i;
          state_d    = CAL_SEARCH;
          trim_inc_o = 1'b1;
          restart_o  = 1'b1;
        end
      end
      CAL_SEARCH: begin
        if (expire_i) begin
          if (flag_i != ref_q) begin
            fin     = 1'b1;
            state_d = CAL_IDLE;
          end else if (at_max_i) begin
            fin     = 1'b1;
            err_set = 1'b1;
            state_d = CAL_IDLE;
          end else begin
            trim_inc_o = 1'b1;
            restart_o  = 1'b1;
          end
        end
      end
      default: state_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CAL_IDLE;
      ref_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      done_q  <= fin;
      if (trim_clr_o)   err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  assign busy_o = (state_q != CAL_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/dac_trim_cal.sv
module dac_trim_cal
  import dac_trim_pkg::*;
#(
  parameter int unsigned TRIM_W   = 5,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned SETTLE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [TRIM_W-1:0]   factory_trim_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_i,
  input  logic                cmp_flag_i,
  input  logic                sw_trim_we_i,
  input  logic [TRIM_W-1:0]   sw_trim_i,
  output logic [TRIM_W-1:0]   trim_o,
  output logic                hiz_o,
  output logic                force_en_o,
  output logic [CODE_W-1:0]   force_code_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                err_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic buf_en, expire, restart, trim_clr, trim_inc, at_max, busy;

  dac_trim_mode_dec u_mode (
    .mode_i   (mode_i),
    .buf_en_o (buf_en)
  );

  dac_trim_settle #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .run_i     (busy),
    .limit_i   (settle_i),
    .expire_o  (expire)
  );

  dac_trim_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .buf_en_i   (buf_en),
    .expire_i   (expire),
    .flag_i     (cmp_flag_i),
    .at_max_i   (at_max),
    .busy_o     (busy),
    .trim_clr_o (trim_clr),
    .trim_inc_o (trim_inc),
    .restart_o  (restart),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  dac_trim_reg #(.TRIM_W(TRIM_W)) u_trim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .factory_i (factory_trim_i),
    .clr_i     (trim_clr),
    .inc_i     (trim_inc),
    .busy_i    (busy),
    .we_i      (sw_trim_we_i),
    .wdata_i   (sw_trim_i),
    .trim_o    (trim_o),
    .at_max_o  (at_max)
  );

  assign busy_o       = busy;
  assign hiz_o        = busy;
  assign force_en_o   = busy;
  assign force_code_o = busy ? MID_CODE : '0;
endmodule

// File: rtl/dac_trim_cal_chk.sv
module dac_trim_cal_chk #(
  parameter int unsigned TRIM_W = 5,
  parameter int unsigned CODE_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        mode_i,
  input logic              start_i,
  input logic [TRIM_W-1:0] trim_o,
  input logic              hiz_o,
  input logic              force_en_o,
  input logic [CODE_W-1:0] force_code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  AST_BUSY_ISOLATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (hiz_o && force_en_o && force_code_o == MID)); // R2

  AST_SEARCH_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (trim_o == '0)); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (trim_o == $past(trim_o) || trim_o == $past(trim_o) + 1'b1)); // R3

  AST_UNBUF_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && mode_i[1]) |=> !busy_o); // R5

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R4

  AST_ERR_AT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (&trim_o)); // R7
endmodule

bind dac_trim_cal dac_trim_cal_chk #(.TRIM_W(TRIM_W), .CODE_W(CODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .start_i      (start_i),
  .trim_o       (trim_o),
  .hiz_o        (hiz_o),
  .force_en_o   (force_en_o),
  .force_code_o (force_code_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/sim_dac_trim_cal.sv
module sim_dac_trim_cal;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  factory = 5'h13;
  logic [2:0]  mode = 3'b000;
  logic        start = 1'b0;
  logic [7:0]  settle = 8'd0;
  logic        flag;
  logic        we = 1'b0;
  logic [4:0]  wdata = 5'd0;
  logic [4:0]  trim;
  logic        hiz, fen, busy, done, err;
  logic [11:0] fcode;

  int tests = 0;
  int fails = 0;
  int toggle_at = 32;
  logic pol = 1'b0;

  always #4 clk = ~clk;

  // comparator model: flag flips once trim reaches toggle_at
  assign flag = ((int'(trim) >= toggle_at) ? 1'b1 : 1'b0) ^ pol;

  dac_trim_cal u0 (
    .clk_i(clk), .rst_ni(rst_n), .factory_trim_i(factory), .mode_i(mode),
    .start_i(start), .settle_i(settle), .cmp_flag_i(flag),
    .sw_trim_we_i(we), .sw_trim_i(wdata), .trim_o(trim), .hiz_o(hiz),
    .force_en_o(fen), .force_code_o(fcode), .busy_o(busy), .done_o(done),
    .err_o(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // run one calibration; optionally poke start / sw write mid-run
  task automatic run_cal(input logic [2:0] m, input int k, input int s,
                         input logic p, input bit poke);
    int n_exp, exp_trim, cnt, bad;
    toggle_at = k;
    pol = p;
    settle = 8'(s);
    n_exp = ((k > 31 ? 31 : k) + 1) * (s + 1);
    exp_trim = (k > 31) ? 31 : k;
    @(negedge clk);
    mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy/hiz/force", {busy, hiz, fen}, 7);
    chk("R2 mid code", int'(fcode), 12'h800);
    chk("R7 err cleared on start", int'(err), 0);
    cnt = 0; bad = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      if (int'(trim) != (cnt - 1) / (s + 1)) bad++;
      if (poke && cnt == 2) begin start = 1'b1; we = 1'b1; wdata = 5'd29; end
      else begin start = 1'b0; we = 1'b0; end
      @(negedge clk);
    end
    start = 1'b0; we = 1'b0;
    chk("R3 stepwise trim", bad, 0);
    chk("R4 busy length", cnt, n_exp);
    chk("R4 result trim", int'(trim), exp_trim);
    chk("R6 done high", int'(done), 1);
    chk("R7 err flag", int'(err), (k > 31) ? 1 : 0);
    chk("R2 code released", int'(fcode), 0);
    @(negedge clk);
    chk("R6 done pulse single", int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 trim in reset", int'(trim), 5'h13);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 trim after reset", int'(trim), 5'h13);
    chk("R1 status", {busy, done, err, hiz, fen}, 0);

    // R8 idle write
    we = 1'b1; wdata = 5'd7;
    @(negedge clk);
    we = 1'b0;
    chk("R8 idle write", int'(trim), 7);

    // R5 every unbuffered mode
    for (int i = 0; i < 4; i++) begin
      logic [2:0] um;
      um = (i < 2) ? 3'(2 + i) : 3'(6 + i - 2);
      mode = um; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      chk("R5 no busy", int'(busy), 0);
      chk("R5 trim kept", int'(trim), 7);
      chk("R5 no done", int'(done), 0);
    end

    // R10 start beats write
    mode = 3'b001; toggle_at = 3; pol = 1'b0; settle = 8'd0;
    start = 1'b1; we = 1'b1; wdata = 5'd21;
    @(negedge clk);
    start = 1'b0; we = 1'b0;
    chk("R10 start wins", int'(trim), 0);
    while (busy) @(negedge clk);
    @(negedge clk);

    // R9/R8 start and write during run ignored
    run_cal(3'b100, 9, 2, 1'b0, 1'b1);

    // R3/R4/R7 sweep over toggle position, settle and polarity
    for (int s = 0; s < 3; s++) begin
      for (int pp = 0; pp < 2; pp++) begin
        for (int k = 1; k <= 32; k++) begin
          logic [2:0] bm;
          bm = ((k & 1) != 0) ? 3'b101 : 3'b000;
          run_cal(bm, k, (s == 2) ? 3 : s, pp[0], 1'b0);
        end
      end
    end

    // R7 err clears after failing run (checked inside run_cal)
    run_cal(3'b000, 32, 0, 1'b1, 1'b0);
    run_cal(3'b001, 4, 1, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule